// File: doc/BRIEF.md
# Deferred Load Retire Station Buffer

This block splits a load into two separate operations. An issue operation sends an address together with a pick token. The block claims a free retire station for that token and passes the request on to a memory port in the same cycle. Later, a pickup operation presents the same token. If the memory response has already been captured, the pickup receives the value at once and the station is released. Because issue and consumption are decoupled, many loads can be in flight before the first value is used. The limit is the number of stations, and the token width caps it further.

The memory side is a plain request/response pair. Each request names the station it belongs to. Responses may come back in any order and name the station they fill. A pickup whose data has not arrived holds its acknowledge low, which stalls the consumer until the data lands. A pickup of a token that no station holds completes at once with an error flag and a zero value.

Top module: `dlb_retire_buf`

## Requirements
- R1: After reset every station is empty. With the memory port ready, issue is ready, and a pickup of any token completes with the error flag set.
- R2: An issue that is accepted drives `mreq_valid` high in the same cycle with `mreq_addr` equal to `iss_addr`. `mreq_valid` is never high without `iss_valid`.
- R3: When all NSTN stations are occupied, `iss_ready` is low.
- R4: When a station already holds the token presented on `iss_token`, `iss_ready` is low, even if other stations are free.
- R5: A memory response writes `mrsp_data` into the station named by `mrsp_stn`. Responses may arrive in any order, and each pickup returns the data of the station that owns its token.
- R6: A pickup whose data is already captured sees `pick_ack` high and `pick_err` low in the same cycle, with `pick_data` set to the value. The station is free from the next cycle, so a second pickup of that token reports an error.
- R7: A pickup of an issued token whose data has not yet been captured keeps `pick_ack` low. It completes in the first cycle after the response edge.
- R8: A pickup of a token held by no station sees `pick_ack` high and `pick_err` high in the same cycle, with `pick_data` equal to zero.
- R9: When `mreq_ready` is low, `iss_ready` is low and no station is claimed.
- R10: An accepted issue claims the lowest-numbered free station, and that index is driven on `mreq_stn`. A station freed by a pickup can be claimed from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Load issue request |
| iss_token | input | TOKEN_W | Pick token of the issued load |
| iss_addr | input | ADDR_W | Load address |
| iss_ready | output | 1 | Issue accepted when high with iss_valid |
| mreq_valid | output | 1 | Memory request valid |
| mreq_addr | output | ADDR_W | Memory request address |
| mreq_stn | output | STN_W | Station that owns the request |
| mreq_ready | input | 1 | Memory port can take a request |
| mrsp_valid | input | 1 | Memory response valid |
| mrsp_stn | input | STN_W | Station the response belongs to |
| mrsp_data | input | DATA_W | Returned load data |
| pick_valid | input | 1 | Pickup request |
| pick_token | input | TOKEN_W | Token to pick up |
| pick_ack | output | 1 | Pickup completes this cycle |
| pick_err | output | 1 | Token not held by any station |
| pick_data | output | DATA_W | Picked-up value, zero on error |

## Verification
The hardest situation to reach is a full pool in which the responses come back in a different order from the requests. At the same moment, a pickup must be waiting on a station that is still empty, and an issue must reuse a token that is still held. A directed prologue fills every station with distinct tokens while keeping responses back. It then returns the data of the third and first stations out of order, with a stalled pickup and blocked issues in between. After that, a long random phase follows from a fixed seed. It draws tokens from a range slightly wider than the station count, so token collisions, unknown-token pickups, memory backpressure and reuse of freed stations all keep recurring.

// File: rtl/dlb_pkg.sv
package dlb_pkg;
  typedef enum logic [1:0] {
    PK_IDLE = 2'd0,
    PK_WAIT = 2'd1,
    PK_HIT  = 2'd2,
    PK_MISS = 2'd3
  } pick_state_e;
endpackage

// File: rtl/dlb_pick_free.sv
module dlb_pick_free #(
  parameter int N   = 4,
  parameter int IW  = 2
) (
  input  logic [N-1:0]  occ,
  output logic          any_free,
  output logic [IW-1:0] idx
);
  always_comb begin
    any_free = 1'b0;
    idx      = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!occ[i]) begin
        any_free = 1'b1;
        idx      = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dlb_tag_match.sv
module dlb_tag_match #(
  parameter int N  = 4,
  parameter int TW = 4,
  parameter int IW = 2
) (
  input  logic [N*TW-1:0] tags,
  input  logic [N-1:0]    occ,
  input  logic [TW-1:0]   key,
  output logic            hit,
  output logic [IW-1:0]   idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = occ[g] && (tags[g*TW +: TW] == key);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (eq[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dlb_retire_buf.sv
module dlb_retire_buf
  import dlb_pkg::*;
#(
  parameter int TOKEN_W = 4,
  parameter int NSTN    = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  localparam int STN_W  = (NSTN > 1) ? $clog2(NSTN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iss_valid,
  input  logic [TOKEN_W-1:0] iss_token,
  input  logic [ADDR_W-1:0]  iss_addr,
  output logic               iss_ready,
  output logic               mreq_valid,
  output logic [ADDR_W-1:0]  mreq_addr,
  output logic [STN_W-1:0]   mreq_stn,
  input  logic               mreq_ready,
  input  logic               mrsp_valid,
  input  logic [STN_W-1:0]   mrsp_stn,
  input  logic [DATA_W-1:0]  mrsp_data,
  input  logic               pick_valid,
  input  logic [TOKEN_W-1:0] pick_token,
  output logic               pick_ack,
  output logic               pick_err,
  output logic [DATA_W-1:0]  pick_data
);
  // station state
  logic [NSTN-1:0]         occ_q, occ_d;
  logic [NSTN-1:0]         ok_q, ok_d;
  logic [NSTN*TOKEN_W-1:0] tok_q;
  logic [DATA_W-1:0]       dat_q [NSTN];

  logic                    free_any;
  logic [STN_W-1:0]        free_idx;
  logic                    iss_hit;
  logic [STN_W-1:0]        iss_hit_idx;
  logic                    pk_hit;
  logic [STN_W-1:0]        pk_idx;
  logic                    iss_ok, iss_fire, pk_release;
  pick_state_e             pk_state;

  dlb_pick_free #(.N(NSTN), .IW(STN_W)) u_free (
    .occ      (occ_q),
    .any_free (free_any),
    .idx      (free_idx)
  );

  dlb_tag_match #(.N(NSTN), .TW(TOKEN_W), .IW(STN_W)) u_iss_match (
    .tags (tok_q),
    .occ  (occ_q),
    .key  (iss_token),
    .hit  (iss_hit),
    .idx  (iss_hit_idx)
  );

  dlb_tag_match #(.N(NSTN), .TW(TOKEN_W), .IW(STN_W)) u_pk_match (
    .tags (tok_q),
    .occ  (occ_q),
    .key  (pick_token),
    .hit  (pk_hit),
    .idx  (pk_idx)
  );

  // issue path: forwarded straight to memory, no buffering
  assign iss_ok     = free_any && !iss_hit;
  assign iss_ready  = iss_ok && mreq_ready;
  assign iss_fire   = iss_valid && iss_ready;
  assign mreq_valid = iss_valid && iss_ok;
  assign mreq_addr  = iss_addr;
  assign mreq_stn   = free_idx;

  // pickup decode
  always_comb begin
    pk_state = PK_IDLE;
    if (pick_valid) begin
      if (!pk_hit)           pk_state = PK_MISS;
      else if (ok_q[pk_idx]) pk_state = PK_HIT;
      else                   pk_state = PK_WAIT;
    end
  end

  assign pk_release = (pk_state == PK_HIT);
  assign pick_ack   = (pk_state == PK_HIT) || (pk_state == PK_MISS);
  assign pick_err   = (pk_state == PK_MISS);
  assign pick_data  = pk_release ? dat_q[pk_idx] : '0;

  // per-station next state and registers
  for (genvar s = 0; s < NSTN; s++) begin : g_stn
    logic claim, drop, fill;

    assign claim = iss_fire && (free_idx == STN_W'(s));
    assign drop  = pk_release && (pk_idx == STN_W'(s));
    assign fill  = mrsp_valid && (mrsp_stn == STN_W'(s)) && occ_q[s];

    always_comb begin
      occ_d[s] = claim || (occ_q[s] && !drop);
      if (claim)      ok_d[s] = 1'b0;
      else if (fill)  ok_d[s] = 1'b1;
      else if (drop)  ok_d[s] = 1'b0;
      else            ok_d[s] = ok_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ_q[s] <= 1'b0;
        ok_q[s]  <= 1'b0;
      end else begin
        occ_q[s] <= occ_d[s];
        ok_q[s]  <= ok_d[s];
      end
    end

    always_ff @(posedge clk) begin
      if (claim) tok_q[s*TOKEN_W +: TOKEN_W] <= iss_token;
      if (fill)  dat_q[s] <= mrsp_data;
    end
  end

endmodule

// File: rtl/dlb_retire_buf_chk.sv
module dlb_retire_buf_chk #(
  parameter int NSTN  = 4,
  parameter int STN_W = 2,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic              mreq_valid,
  input logic              mreq_ready,
  input logic [STN_W-1:0]  mreq_stn,
  input logic              pick_valid,
  input logic              pick_ack,
  input logic              pick_err,
  input logic [DATA_W-1:0] pick_data,
  input logic [NSTN-1:0]   occ_q,
  input logic [STN_W-1:0]  pk_idx
);
  p_req_needs_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> iss_valid);

  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&occ_q) |-> !iss_ready);

  p_claim_sticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> occ_q[$past(mreq_stn)]);

  p_pick_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && pick_ack && !pick_err) |=> !occ_q[$past(pk_idx)]);

  p_wait_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && !pick_ack) |-> !pick_err);

  p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pick_err |-> (pick_ack && pick_data == '0));

  p_mem_bp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mreq_ready |-> !iss_ready);
endmodule

bind dlb_retire_buf dlb_retire_buf_chk #(.NSTN(NSTN), .STN_W(STN_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .iss_valid  (iss_valid),
  .iss_ready  (iss_ready),
  .mreq_valid (mreq_valid),
  .mreq_ready (mreq_ready),
  .mreq_stn   (mreq_stn),
  .pick_valid (pick_valid),
  .pick_ack   (pick_ack),
  .pick_err   (pick_err),
  .pick_data  (pick_data),
  .occ_q      (occ_q),
  .pk_idx     (pk_idx)
);

// File: tb/sim_dlb_retire_buf.sv
module sim_dlb_retire_buf;
  localparam int TW = 4;
  localparam int NS = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SW = 2;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 3000;

  logic          clk, rst_n;
  logic          iss_valid;
  logic [TW-1:0] iss_token;
  logic [AW-1:0] iss_addr;
  logic          iss_ready;
  logic          mreq_valid;
  logic [AW-1:0] mreq_addr;
  logic [SW-1:0] mreq_stn;
  logic          mreq_ready;
  logic          mrsp_valid;
  logic [SW-1:0] mrsp_stn;
  logic [DW-1:0] mrsp_data;
  logic          pick_valid;
  logic [TW-1:0] pick_token;
  logic          pick_ack, pick_err;
  logic [DW-1:0] pick_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model of the stations
  bit            m_occ [NS];
  bit            m_ok  [NS];
  logic [TW-1:0] m_tok [NS];
  logic [AW-1:0] m_adr [NS];

  dlb_retire_buf #(.TOKEN_W(TW), .NSTN(NS), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_token(iss_token), .iss_addr(iss_addr), .iss_ready(iss_ready),
    .mreq_valid(mreq_valid), .mreq_addr(mreq_addr), .mreq_stn(mreq_stn), .mreq_ready(mreq_ready),
    .mrsp_valid(mrsp_valid), .mrsp_stn(mrsp_stn), .mrsp_data(mrsp_data),
    .pick_valid(pick_valid), .pick_token(pick_token),
    .pick_ack(pick_ack), .pick_err(pick_err), .pick_data(pick_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return {~a, a} ^ 32'h3c96_a55a;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare, then advance model at posedge
  task automatic step(input bit iv, input logic [TW-1:0] itok, input logic [AW-1:0] iadr,
                      input bit mrdy, input bit rv, input logic [SW-1:0] rstn,
                      input bit pv, input logic [TW-1:0] ptok);
    bit free_any, tok_busy, e_rdy, e_req, p_hit, e_ack, e_err, e_fire;
    int free_i, p_i;
    logic [DW-1:0] e_dat;
    string rtag;
    @(negedge clk);
    iss_valid = iv; iss_token = itok; iss_addr = iadr; mreq_ready = mrdy;
    mrsp_valid = rv; mrsp_stn = rstn; mrsp_data = mem_val(m_adr[rstn]);
    pick_valid = pv; pick_token = ptok;
    #1;
    free_any = 0; free_i = 0; tok_busy = 0; p_hit = 0; p_i = 0;
    for (int i = NS - 1; i >= 0; i--) if (!m_occ[i]) begin free_any = 1; free_i = i; end
    for (int i = 0; i < NS; i++) begin
      if (m_occ[i] && m_tok[i] == itok) tok_busy = 1;
      if (m_occ[i] && m_tok[i] == ptok) begin p_hit = 1; p_i = i; end
    end
    e_req  = iv && free_any && !tok_busy;
    e_rdy  = free_any && !tok_busy && mrdy;
    e_fire = iv && e_rdy;
    rtag = !free_any ? "R3" : (tok_busy ? "R4" : "R9");
    check(rtag, DW'(iss_ready), DW'(e_rdy));
    check("R2", DW'(mreq_valid), DW'(e_req));
    if (e_req) begin
      check("R2", DW'(mreq_addr), DW'(iadr));
      check("R10", DW'(mreq_stn), DW'(free_i));
    end
    e_ack = pv && (!p_hit || m_ok[p_i]);
    e_err = pv && !p_hit;
    e_dat = (pv && p_hit && m_ok[p_i]) ? mem_val(m_adr[p_i]) : '0;
    if (pv && !p_hit)        begin check("R8", DW'(pick_ack), DW'(e_ack)); check("R8", DW'(pick_err), 1); check("R8", pick_data, 0); end
    else if (pv && !m_ok[p_i]) check("R7", DW'(pick_ack), DW'(e_ack));
    else if (pv)             begin check("R6", DW'(pick_ack), 1); check("R6", DW'(pick_err), 0); check("R5", pick_data, e_dat); end
    @(posedge clk);
    #1;
    if (pv && p_hit && m_ok[p_i]) begin m_occ[p_i] = 0; m_ok[p_i] = 0; end
    if (rv && m_occ[rstn]) m_ok[rstn] = 1;
    if (e_fire) begin
      m_occ[free_i] = 1; m_ok[free_i] = 0; m_tok[free_i] = itok; m_adr[free_i] = iadr;
    end
  endtask

  initial begin : watchdog
    repeat (200000 - 1000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < NS; i++) begin m_occ[i] = 0; m_ok[i] = 0; m_tok[i] = '0; m_adr[i] = '0; end
    rst_n = 1'b0;
    iss_valid = 0; iss_token = '0; iss_addr = '0; mreq_ready = 1;
    mrsp_valid = 0; mrsp_stn = '0; mrsp_data = '0; pick_valid = 0; pick_token = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: empty after reset, issue ready, pickup of any token errors
    check("R1", DW'(iss_ready), 1);
    step(0, 0, 0, 1, 0, 0, 1, 4'd5);

    // fill all stations with tokens 1..4 (R10 lowest free)
    for (int t = 1; t <= NS; t++) step(1, TW'(t), AW'(16'h1000 + t), 1, 0, 0, 0, 0);
    step(1, 4'd9, 16'h2222, 1, 0, 0, 0, 0);      // R3 full
    step(0, 0, 0, 1, 0, 0, 1, 4'd3);             // R7 stall on token 3 (station 2)
    step(0, 0, 0, 1, 1, 2'd2, 1, 4'd3);          // response lands, pickup still waits
    step(0, 0, 0, 1, 1, 2'd0, 1, 4'd3);          // R5/R7 completes, R5 out of order fill of station 0
    step(1, 4'd1, 16'h3333, 1, 0, 0, 1, 4'd3);   // R4 token 1 busy; R6 second pickup errors
    step(1, 4'd3, 16'h4444, 0, 0, 0, 1, 4'd1);   // R9 memory stall; R6 pickup token 1
    step(1, 4'd3, 16'h4444, 1, 0, 0, 0, 0);      // R10 reuses station 0

    // random phase
    for (int c = 0; c < RAND_CYCLES; c++) begin
      bit iv, mrdy, rv, pv;
      logic [SW-1:0] rs;
      int start;
      iv   = ($urandom_range(0, 99) < 55);
      mrdy = ($urandom_range(0, 99) < 80);
      pv   = ($urandom_range(0, 99) < 45);
      rv   = 0; rs = '0;
      start = $urandom_range(0, NS - 1);
      if ($urandom_range(0, 99) < 50)
        for (int k = 0; k < NS; k++) begin
          int j;
          j = (start + k) % NS;
          if (!rv && m_occ[j] && !m_ok[j]) begin rv = 1; rs = SW'(j); end
        end
      step(iv, TW'($urandom_range(0, 6)), AW'($urandom), mrdy, rv, rs, pv, TW'($urandom_range(0, 6)));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule